// File: doc/BRIEF.md
# Frame Memory Write-Path Mode Controller

This block decides who may write the on-chip frame memory of a display controller and when. Writes can come from a host bus, which delivers one addressed word at a time, or from a streaming pixel bus that delivers one 18-bit pixel per dot-clock edge. A two-bit display-mode field and a one-bit memory-source select, both held in configuration registers, choose which path is allowed. The configuration registers are loaded only from the configuration port.

In streaming (RGB) mode the block works out the vertical frame structure itself. It counts line-sync pulses since the last frame-sync and compares the count against programmable back-porch, active-line and front-porch counts. Pixels that arrive during active lines while the data-enable input is low are written at an address that walks a programmable window. The address starts at a programmed corner, moves right, and wraps to the left edge of the next row after the right edge. Host writes are checked against the current mode. A write that is not allowed leaves the memory untouched and raises a one-cycle error flag. A synchronous read port exposes the memory contents.

All external sync, dot-clock and enable inputs are sampled in the `clk` domain, and an event is their rising edge as seen by `clk`.

Top module: `fbw_wpath_ctrl`

## Requirements
- R1: After reset, `act_mode` is 0 (internal), `line_phase` is 0 (back porch) and `hst_err` is 0. The memory source select resets to host (0).
- R2: A write to configuration address 0 sets the mode field from bits [1:0] (0 internal, 1 RGB, 2 VSYNC-driven) and the source select from bit [2] (0 host, 1 pixel bus). A write whose mode field is 3 is rejected as a whole. When the active mode is not RGB, an accepted mode reaches `act_mode` two clock edges after the write.
- R3: While `act_mode` is 1, a new mode takes effect only on the next frame-sync rising edge. A write that would go directly between 1 and 2, against either the pending or the active mode, is rejected.
- R4: In internal mode, sync, dot-clock, enable and pixel inputs have no effect on the memory or on `line_phase`. Host writes are accepted whatever the source select is.
- R5: Let n be the number of line-sync rising edges since the last frame-sync rising edge, with the counts at configuration addresses 1 (BP), 2 (NL) and 3 (FP). `line_phase` is 0 while n <= BP, 1 while BP < n <= BP+NL, and 2 after that.
- R6: Each frame-sync rising edge in RGB mode clears n to 0. Line-sync pulses after BP+NL+FP keep `line_phase` at 2 until the next frame-sync.
- R7: In RGB mode with source select 1, a dot-clock rising edge writes `pix_data` to memory only when `line_phase` is 1 and `enable` is low. Pixels offered with `enable` high, or outside active lines, are dropped and do not advance the address.
- R8: Memory address is row*2^COL_W+column. After each captured pixel the column steps by one. A capture at the right edge (config 5) moves to the left edge (config 4) of the next row.
- R9: In RGB mode with source select 0, a host write is accepted only while `enable` is high. In VSYNC-driven mode with source select 0, host writes are always accepted.
- R10: A rejected host write (RGB mode with `enable` low, or source select 1 outside internal mode) leaves memory unchanged. It drives `hst_err` high for exactly the following cycle.
- R11: The write address is reloaded from the address-set registers (column at config 6, row at config 7) on every RGB frame-sync edge. It is also reloaded when an accepted mode write changes the source select from 0 to 1, so capture resumes at the programmed corner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | CFG_W | Configuration write data |
| hst_we | input | 1 | Host memory write request |
| hst_addr | input | COL_W+ROW_W | Host memory write address |
| hst_wdata | input | PIX_W | Host memory write data |
| hst_err | output | 1 | One-cycle flag for a rejected host write |
| vsync | input | 1 | Frame sync, rising edge starts a frame |
| hsync | input | 1 | Line sync, rising edge starts a line |
| dotclk | input | 1 | Pixel clock, rising edge offers a pixel |
| enable | input | 1 | Data enable, low while pixels are transferred |
| pix_data | input | PIX_W | Streaming pixel word |
| rd_addr | input | COL_W+ROW_W | Memory read address |
| rd_data | output | PIX_W | Memory read data, one cycle after `rd_addr` |
| act_mode | output | 2 | Mode currently in force |
| line_phase | output | 2 | 0 back porch, 1 active line, 2 front porch |

## Verification
The assertions assume that a frame-sync, line-sync and dot-clock rising edge never fall in the same `clk` cycle. They also assume each sync input is a clean level held for at least one cycle, so every rising edge is one event. The stimulus enforces this by raising each of these inputs for exactly one cycle and returning it low before the next one is raised. Configuration writes are never issued in the cycle of a frame-sync edge. `enable` is held high except inside a pixel or host-write cycle that deliberately tests it.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

   typedef enum logic [1:0] {
      DM_INT = 2'd0,
      DM_RGB = 2'd1,
      DM_VSY = 2'd2,
      DM_RSV = 2'd3
   } dmode_e;

   localparam logic [1:0] PH_BACK  = 2'd0;
   localparam logic [1:0] PH_ACT   = 2'd1;
   localparam logic [1:0] PH_FRONT = 2'd2;

   localparam logic [2:0] CFG_MODE = 3'd0;
   localparam logic [2:0] CFG_BP   = 3'd1;
   localparam logic [2:0] CFG_NL   = 3'd2;
   localparam logic [2:0] CFG_FP   = 3'd3;
   localparam logic [2:0] CFG_WL   = 3'd4;
   localparam logic [2:0] CFG_WR   = 3'd5;
   localparam logic [2:0] CFG_AX   = 3'd6;
   localparam logic [2:0] CFG_AY   = 3'd7;

   function automatic logic cross_switch(input dmode_e a, input dmode_e b);
      return (a == DM_RGB && b == DM_VSY) || (a == DM_VSY && b == DM_RGB);
   endfunction

endpackage

// File: rtl/fbw_edge.sv
module fbw_edge #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise
);
   for (genvar gi = 0; gi < N; gi++) begin : g_bit
      logic prev;
      always_ff @(posedge clk) begin
         if (!rst_n) prev <= 1'b0;
         else        prev <= din[gi];
      end
      assign rise[gi] = din[gi] & ~prev;
   end
endmodule

// File: rtl/fbw_line_trk.sv
module fbw_line_trk
   import fbw_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          clr,
   input  logic          step,
   input  logic [CW-1:0] bp,
   input  logic [CW-1:0] nl,
   input  logic [CW-1:0] fp,
   output logic [1:0]    phase
);
   localparam int NW = CW + 2;

   logic [NW-1:0] cnt;
   logic [NW-1:0] back_end;
   logic [NW-1:0] act_end;
   logic [NW-1:0] total;

   assign back_end = {2'b00, bp};
   assign act_end  = back_end + {2'b00, nl};
   assign total    = act_end + {2'b00, fp};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (en) begin
         if (clr)                      cnt <= '0;
         else if (step && cnt < total) cnt <= cnt + 1'b1;
      end
   end

   always_comb begin
      if (cnt <= back_end)     phase = PH_BACK;
      else if (cnt <= act_end) phase = PH_ACT;
      else                     phase = PH_FRONT;
   end
endmodule

// File: rtl/fbw_addr_step.sv
module fbw_addr_step #(
   parameter int XW = 4,
   parameter int YW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [XW-1:0]    ld_x,
   input  logic [YW-1:0]    ld_y,
   input  logic [XW-1:0]    win_l,
   input  logic [XW-1:0]    win_r,
   output logic [XW+YW-1:0] addr
);
   logic [XW-1:0] col;
   logic [YW-1:0] row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col <= '0;
         row <= '0;
      end else if (load) begin
         col <= ld_x;
         row <= ld_y;
      end else if (step) begin
         if (col == win_r) begin
            col <= win_l;
            row <= row + 1'b1;
         end else begin
            col <= col + 1'b1;
         end
      end
   end

   assign addr = {row, col};
endmodule

// File: rtl/fbw_ram.sv
module fbw_ram #(
   parameter int DW = 18,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/fbw_wpath_ctrl.sv
module fbw_wpath_ctrl
   import fbw_pkg::*;
#(
   parameter int PIX_W = 18,
   parameter int COL_W = 4,
   parameter int ROW_W = 4,
   parameter int LCW   = 8,
   parameter int CFG_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [2:0]             cfg_addr,
   input  logic [CFG_W-1:0]       cfg_wdata,
   input  logic                   hst_we,
   input  logic [COL_W+ROW_W-1:0] hst_addr,
   input  logic [PIX_W-1:0]       hst_wdata,
   output logic                   hst_err,
   input  logic                   vsync,
   input  logic                   hsync,
   input  logic                   dotclk,
   input  logic                   enable,
   input  logic [PIX_W-1:0]       pix_data,
   input  logic [COL_W+ROW_W-1:0] rd_addr,
   output logic [PIX_W-1:0]       rd_data,
   output logic [1:0]             act_mode,
   output logic [1:0]             line_phase
);
   localparam int AW = COL_W + ROW_W;

   initial begin
      assert (PIX_W > 0 && COL_W > 0 && ROW_W > 0 && LCW > 0)
         else $error("fbw_wpath_ctrl: widths must be positive");
      assert (CFG_W >= LCW && CFG_W >= COL_W && CFG_W >= ROW_W && CFG_W >= 3)
         else $error("fbw_wpath_ctrl: CFG_W too narrow for its fields");
   end

   // edge events on the streaming inputs
   logic [2:0] rise;
   logic       vs_rise, hs_rise, dc_rise;

   fbw_edge #(.N(3)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({vsync, hsync, dotclk}),
      .rise (rise)
   );
   assign vs_rise = rise[2];
   assign hs_rise = rise[1];
   assign dc_rise = rise[0];

   // configuration state
   dmode_e           pend_q, act_q;
   logic             src_pix;
   logic [LCW-1:0]   bp_q, nl_q, fp_q;
   logic [COL_W-1:0] wl_q, wr_q, ax_q;
   logic [ROW_W-1:0] ay_q;

   dmode_e new_mode;
   logic   mode_wr, mode_ok, sel_rise;

   assign new_mode = dmode_e'(cfg_wdata[1:0]);
   assign mode_wr  = cfg_we && (cfg_addr == CFG_MODE);
   assign mode_ok  = (new_mode != DM_RSV) && !cross_switch(new_mode, pend_q)
                     && !cross_switch(new_mode, act_q);
   assign sel_rise = mode_wr && mode_ok && cfg_wdata[2] && !src_pix;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= DM_INT;
         src_pix <= 1'b0;
         bp_q    <= '0;
         nl_q    <= '0;
         fp_q    <= '0;
         wl_q    <= '0;
         wr_q    <= '0;
         ax_q    <= '0;
         ay_q    <= '0;
      end else if (cfg_we) begin
         unique case (cfg_addr)
            CFG_MODE: if (mode_ok) begin
               pend_q  <= new_mode;
               src_pix <= cfg_wdata[2];
            end
            CFG_BP:  bp_q <= cfg_wdata[LCW-1:0];
            CFG_NL:  nl_q <= cfg_wdata[LCW-1:0];
            CFG_FP:  fp_q <= cfg_wdata[LCW-1:0];
            CFG_WL:  wl_q <= cfg_wdata[COL_W-1:0];
            CFG_WR:  wr_q <= cfg_wdata[COL_W-1:0];
            CFG_AX:  ax_q <= cfg_wdata[COL_W-1:0];
            CFG_AY:  ay_q <= cfg_wdata[ROW_W-1:0];
            default: ;
         endcase
      end
   end

   // the active mode follows the pending one, gated by frame sync in RGB mode
   always_ff @(posedge clk) begin
      if (!rst_n)                  act_q <= DM_INT;
      else if (act_q != DM_RGB)    act_q <= pend_q;
      else if (vs_rise)            act_q <= pend_q;
   end

   logic rgb_on;
   assign rgb_on = (act_q == DM_RGB);

   fbw_line_trk #(.CW(LCW)) u_lines (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (rgb_on),
      .clr  (vs_rise),
      .step (hs_rise),
      .bp   (bp_q),
      .nl   (nl_q),
      .fp   (fp_q),
      .phase(line_phase)
   );

   // write-source arbitration
   logic pix_we, host_ok, host_acc;
   assign pix_we   = rgb_on && src_pix && (line_phase == PH_ACT) && !enable && dc_rise;
   assign host_ok  = (act_q == DM_INT) || (!src_pix && (!rgb_on || enable));
   assign host_acc = hst_we && host_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) hst_err <= 1'b0;
      else        hst_err <= hst_we && !host_ok;
   end

   logic [AW-1:0] pix_addr;

   fbw_addr_step #(.XW(COL_W), .YW(ROW_W)) u_addr (
      .clk  (clk),
      .rst_n(rst_n),
      .load ((rgb_on && vs_rise) || sel_rise),
      .step (pix_we),
      .ld_x (ax_q),
      .ld_y (ay_q),
      .win_l(wl_q),
      .win_r(wr_q),
      .addr (pix_addr)
   );

   fbw_ram #(.DW(PIX_W), .AW(AW)) u_ram (
      .clk  (clk),
      .we   (pix_we || host_acc),
      .waddr(pix_we ? pix_addr : hst_addr),
      .wdata(pix_we ? pix_data : hst_wdata),
      .raddr(rd_addr),
      .rdata(rd_data)
   );

   assign act_mode = act_q;
endmodule

// File: rtl/fbw_wpath_chk.sv
module fbw_wpath_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic       hst_we,
   input logic       hst_err,
   input logic       enable,
   input logic [1:0] act_mode,
   input logic [1:0] line_phase,
   input logic       vs_rise,
   input logic       pix_we,
   input logic       host_acc
);
   p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      act_mode != 2'd3);

   p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(($past(act_mode) == 2'd1 && act_mode == 2'd2) ||
        ($past(act_mode) == 2'd2 && act_mode == 2'd1)));

   p_rgb_exit_at_vs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act_mode) == 2'd1 && act_mode != 2'd1) |-> $past(vs_rise));

   p_int_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act_mode) == 2'd0 && !$past(cfg_we)) |-> $stable(line_phase));

   p_vs_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(vs_rise && act_mode == 2'd1) |-> line_phase == 2'd0);

   p_src_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_we && host_acc));

   p_host_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_acc && act_mode == 2'd1) |-> enable);

   p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hst_err |-> ($past(hst_we) && !$past(host_acc)));
endmodule

bind fbw_wpath_ctrl fbw_wpath_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .hst_we    (hst_we),
   .hst_err   (hst_err),
   .enable    (enable),
   .act_mode  (act_mode),
   .line_phase(line_phase),
   .vs_rise   (vs_rise),
   .pix_we    (pix_we),
   .host_acc  (host_acc)
);

// File: tb/test_fbw_wpath_ctrl.sv
`timescale 1ns/1ps
module test_fbw_wpath_ctrl;
   localparam int PW = 18;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [15:0]   cfg_wdata = '0;
   logic          hst_we = 1'b0;
   logic [AW-1:0] hst_addr = '0;
   logic [PW-1:0] hst_wdata = '0;
   logic          hst_err;
   logic          vsync = 1'b0, hsync = 1'b0, dotclk = 1'b0, enable = 1'b1;
   logic [PW-1:0] pix_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [PW-1:0] rd_data;
   logic [1:0]    act_mode, line_phase;

   always #4 clk = ~clk;

   fbw_wpath_ctrl i_fbw_wpath_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .hst_we(hst_we), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_err(hst_err), .vsync(vsync), .hsync(hsync),
      .dotclk(dotclk), .enable(enable), .pix_data(pix_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .act_mode(act_mode), .line_phase(line_phase)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_ram [256];
   int m_rd, m_act, m_pend, m_sel, m_cnt, m_err, m_x, m_y;
   int m_bp, m_nl, m_fp, m_wl, m_wr, m_ax, m_ay;
   int m_pv, m_ph, m_pd;

   function automatic int m_phase();
      if (m_cnt <= m_bp) return 0;
      if (m_cnt <= m_bp + m_nl) return 1;
      return 2;
   endfunction

   function automatic bit crossing(input int a, input int b);
      return (a == 1 && b == 2) || (a == 2 && b == 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_ram[i]) m_ram[i] = -1;
         m_rd = -1; m_act = 0; m_pend = 0; m_sel = 0; m_cnt = 0; m_err = 0;
         m_x = 0; m_y = 0; m_bp = 0; m_nl = 0; m_fp = 0; m_wl = 0; m_wr = 0;
         m_ax = 0; m_ay = 0; m_pv = 0; m_ph = 0; m_pd = 0;
      end else begin
         bit vr, hr, dr, ok, cap, mok, srise;
         int nm;
         vr = vsync && !m_pv;
         hr = hsync && !m_ph;
         dr = dotclk && !m_pd;
         m_rd = m_ram[rd_addr];
         ok = (m_act == 0) || (m_sel == 0 && (m_act != 1 || enable));
         m_err = (hst_we && !ok) ? 1 : 0;
         cap = (m_act == 1 && m_sel == 1 && m_phase() == 1 && !enable && dr);
         if (hst_we && ok) m_ram[hst_addr] = int'(hst_wdata);
         if (cap) m_ram[m_y * 16 + m_x] = int'(pix_data);
         nm = int'(cfg_wdata[1:0]);
         mok = (nm != 3) && !crossing(nm, m_pend) && !crossing(nm, m_act);
         srise = cfg_we && cfg_addr == 3'd0 && mok && cfg_wdata[2] && m_sel == 0;
         if ((m_act == 1 && vr) || srise) begin
            m_x = m_ax; m_y = m_ay;
         end else if (cap) begin
            if (m_x == m_wr) begin m_x = m_wl; m_y = (m_y + 1) % 16; end
            else m_x = (m_x + 1) % 16;
         end
         if (m_act == 1) begin
            if (vr) m_cnt = 0;
            else if (hr && m_cnt < m_bp + m_nl + m_fp) m_cnt++;
         end
         if (m_act != 1 || vr) m_act = m_pend;
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: if (mok) begin m_pend = nm; m_sel = int'(cfg_wdata[2]); end
               3'd1: m_bp = int'(cfg_wdata[7:0]);
               3'd2: m_nl = int'(cfg_wdata[7:0]);
               3'd3: m_fp = int'(cfg_wdata[7:0]);
               3'd4: m_wl = int'(cfg_wdata[3:0]);
               3'd5: m_wr = int'(cfg_wdata[3:0]);
               3'd6: m_ax = int'(cfg_wdata[3:0]);
               default: m_ay = int'(cfg_wdata[3:0]);
            endcase
         end
         m_pv = vsync; m_ph = hsync; m_pd = dotclk;
      end
   end

   // compare on every clock, half a period after the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 act_mode vs model", int'(act_mode), m_act);
         chk("R5 line_phase vs model", int'(line_phase), m_phase());
         chk("R10 hst_err vs model", int'(hst_err), m_err);
         if (m_rd >= 0) chk("R7 rd_data vs model", int'(rd_data), m_rd);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg_wr(input logic [2:0] a, input int d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic host_wr(input int a, input int d, input logic en_v);
      @(negedge clk); hst_we = 1'b1; hst_addr = AW'(a); hst_wdata = PW'(d); enable = en_v;
      @(negedge clk); hst_we = 1'b0; enable = 1'b1;
   endtask

   task automatic vs_pulse();
      @(negedge clk); vsync = 1'b1;
      @(negedge clk); vsync = 1'b0;
   endtask

   task automatic hs_pulse();
      @(negedge clk); hsync = 1'b1;
      @(negedge clk); hsync = 1'b0;
   endtask

   task automatic dot_pulse(input logic en_v, input int d);
      @(negedge clk); dotclk = 1'b1; enable = en_v; pix_data = PW'(d);
      @(negedge clk); dotclk = 1'b0; enable = 1'b1;
   endtask

   task automatic rd_chk(input string tag, input int a, input int exp);
      @(negedge clk); rd_addr = AW'(a);
      @(negedge clk); chk(tag, int'(rd_data), exp);
   endtask

   function automatic int initv(input int a);
      return (a * 37 + 5) & 18'h3FFFF;
   endfunction

   localparam int P = 18'h30000;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset act_mode", int'(act_mode), 0);
      chk("R1 reset line_phase", int'(line_phase), 0);
      chk("R1 reset hst_err", int'(hst_err), 0);

      // fill the memory from the host in internal mode
      for (int a = 0; a < 256; a++) begin
         @(negedge clk); hst_we = 1'b1; hst_addr = AW'(a); hst_wdata = PW'(initv(a));
      end
      @(negedge clk); hst_we = 1'b0;

      // R4: internal mode, source select 1, streaming inputs have no effect
      cfg_wr(3'd0, 3'b100);
      wait_n(2);
      host_wr(5, 18'h155, 1'b1);
      chk("R4 host accepted in internal mode", int'(hst_err), 0);
      vs_pulse(); hs_pulse(); hs_pulse();
      dot_pulse(1'b0, 18'h2AAAA);
      chk("R4 line_phase frozen", int'(line_phase), 0);
      rd_chk("R4 host write landed", 5, 18'h155);
      rd_chk("R4 pixel ignored", 0, initv(0));

      // configure timing and window
      cfg_wr(3'd1, 2); cfg_wr(3'd2, 3); cfg_wr(3'd3, 2);
      cfg_wr(3'd4, 2); cfg_wr(3'd5, 4); cfg_wr(3'd6, 3); cfg_wr(3'd7, 1);
      cfg_wr(3'd0, 3'b000);
      wait_n(2);
      cfg_wr(3'd0, 3'b101);
      wait_n(2);
      chk("R2 mode 1 selected", int'(act_mode), 1);

      vs_pulse();
      chk("R6 phase after frame sync", int'(line_phase), 0);
      hs_pulse(); hs_pulse();
      chk("R5 still back porch at n=BP", int'(line_phase), 0);
      hs_pulse();
      chk("R5 active at n=BP+1", int'(line_phase), 1);
      dot_pulse(1'b0, P + 0);
      dot_pulse(1'b0, P + 1);
      dot_pulse(1'b0, P + 2);
      dot_pulse(1'b1, P + 9);
      dot_pulse(1'b0, P + 3);
      dot_pulse(1'b0, P + 4);
      dot_pulse(1'b0, P + 5);
      rd_chk("R7 first pixel at start corner", 8'h13, P + 0);
      rd_chk("R8 right edge column", 8'h14, P + 1);
      rd_chk("R8 wrap to left edge next row", 8'h22, P + 2);
      rd_chk("R7 enable-high pixel dropped", 8'h23, P + 3);
      rd_chk("R8 second wrap", 8'h32, P + 5);
      rd_chk("R8 beyond right edge untouched", 8'h15, initv(8'h15));
      hs_pulse(); hs_pulse();
      chk("R5 active at n=BP+NL", int'(line_phase), 1);
      hs_pulse();
      chk("R5 front porch at n=BP+NL+1", int'(line_phase), 2);
      for (int k = 0; k < 4; k++) hs_pulse();
      chk("R6 extra lines stay front porch", int'(line_phase), 2);
      dot_pulse(1'b0, P + 7);
      rd_chk("R7 no capture in front porch", 8'h33, initv(8'h33));

      // R3: deferred exit from RGB, cross switches rejected
      cfg_wr(3'd0, 3'b100);
      wait_n(3);
      chk("R3 change waits for frame sync", int'(act_mode), 1);
      cfg_wr(3'd0, 3'b110);
      wait_n(2);
      vs_pulse();
      chk("R3 takes effect at frame sync", int'(act_mode), 0);
      cfg_wr(3'd0, 3'b010);
      wait_n(2);
      chk("R2 mode 2 selected", int'(act_mode), 2);
      cfg_wr(3'd0, 3'b001);
      wait_n(2);
      chk("R3 direct 2 to 1 rejected", int'(act_mode), 2);
      host_wr(8'h50, 18'h0BEEF, 1'b0);
      chk("R9 host accepted in mode 2 source host", int'(hst_err), 0);
      cfg_wr(3'd0, 3'b011);
      wait_n(2);
      chk("R2 reserved mode rejected", int'(act_mode), 2);
      cfg_wr(3'd0, 3'b000);
      wait_n(2);
      chk("R2 mode 0 selected", int'(act_mode), 0);
      cfg_wr(3'd0, 3'b001);
      wait_n(2);
      chk("R2 mode 1 with host source", int'(act_mode), 1);

      // R9 / R10: host writes in RGB mode with host source
      host_wr(8'h40, 18'h01234, 1'b1);
      chk("R9 accepted with enable high", int'(hst_err), 0);
      host_wr(8'h41, 18'h00ABC, 1'b0);
      chk("R10 error pulse on reject", int'(hst_err), 1);
      @(negedge clk);
      chk("R10 error lasts one cycle", int'(hst_err), 0);
      rd_chk("R9 accepted data stored", 8'h40, 18'h01234);
      rd_chk("R10 rejected write left memory", 8'h41, initv(8'h41));

      // R11: reload on source switch to pixel bus
      vs_pulse(); hs_pulse(); hs_pulse(); hs_pulse();
      cfg_wr(3'd6, 6); cfg_wr(3'd7, 5);
      cfg_wr(3'd0, 3'b101);
      wait_n(1);
      dot_pulse(1'b0, P + 8'h56);
      rd_chk("R11 capture resumes at new corner", 8'h56, P + 8'h56);
      rd_chk("R11 old corner not rewritten", 8'h13, P + 0);
      host_wr(8'h42, 18'h00777, 1'b1);
      chk("R10 reject with pixel source", int'(hst_err), 1);
      rd_chk("R10 memory unchanged", 8'h42, initv(8'h42));

      wait_n(2);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog actual=timeout expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule